// File: doc/BRIEF.md
# Logarithmic-Depth Prefix Binary Adder

This block is a purely combinational adder for two unsigned operands and a carry-in. It returns a sum of the same width and a carry-out. The carries come from a tree of associative generate/propagate combine cells rather than from a rippling chain, so the carry path grows with the logarithm of the width.

Each bit first forms a generate, a propagate and a half-sum. The carry-in occupies a virtual position below bit zero, so every group that reaches down to that position yields a finished carry. Each tree level doubles the reach of a combine. Cells whose group already reaches the carry-in position keep only the generate half of the result. A post stage XORs each half-sum with its incoming carry.

A parameter selects a sparse variant. In that variant the tree runs over 4-bit slices, using slice-level generate/propagate pairs, and produces only the carry into each slice. A short ripple chain then completes each slice.

Top module: `ks_adder`

## Requirements
- R1: In full-tree mode, {co, sum} equals opa + opb + ci for every operand pair and carry-in.
- R2: In sparse mode, {co, sum} equals opa + opb + ci for every operand pair and carry-in.
- R3: With both operands zero, sum equals the carry-in zero-extended and co is 0.
- R4: When opa XOR opb is all ones, the carry-in travels the full width: sum is all ones if ci is 0, all zeros if ci is 1, and co equals ci.
- R5: When bit WIDTH-1 of both operands is 1, co is 1 whatever the lower bits and ci.
- R6: With both operands all ones, sum equals all ones shifted left by one with ci in bit 0, and co is 1.
- R7: R1 and R2 also hold at a width of 8 bits. Every operand pair and both carry-in values are covered there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| ci | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| co | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The hardest case to reach is a carry that must cross every tree level and every slice boundary. That only happens when all propagate bits are set and the carry-in or a low generate bit is the source. Random operands almost never produce it. Directed vectors therefore force an all-propagate pattern with each carry-in value, a single low generate under all-propagate upper bits, and both operands all ones. The 8-bit instances are swept over every input combination, so every path through the tree and through each slice ripple is exercised in both build modes.

// File: rtl/ks_adder.sv
module ks_adder #(
  parameter int WIDTH  = 16,
  parameter bit SPARSE = 1'b0
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             ci,
  output logic [WIDTH-1:0] sum,
  output logic             co
);
  localparam int LV  = $clog2(WIDTH);
  localparam int NG  = WIDTH / 4;
  localparam int SLV = $clog2(NG);

  logic [WIDTH-1:0] gen, prp, hs;
  assign gen = opa & opb;
  assign prp = opa | opb;
  assign hs  = opa ^ opb;

  generate
    if (!SPARSE) begin : g_full
      logic [LV:0][WIDTH-1:0] gg, pp;
      assign gg[0][0] = ci;
      assign pp[0][0] = 1'b0;
      for (genvar j = 1; j < WIDTH; j++) begin : g_in
        assign gg[0][j] = gen[j-1];
        assign pp[0][j] = prp[j-1];
      end
      for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int SP = 1 << l;
        for (genvar j = 0; j < WIDTH; j++) begin : g_node
          if (j < SP) begin : g_pass
            assign gg[l+1][j] = gg[l][j];
            assign pp[l+1][j] = pp[l][j];
          end else if (j < 2*SP) begin : g_gray
            assign gg[l+1][j] = gg[l][j] | (pp[l][j] & gg[l][j-SP]);
            assign pp[l+1][j] = 1'b0;
          end else begin : g_black
            assign gg[l+1][j] = gg[l][j] | (pp[l][j] & gg[l][j-SP]);
            assign pp[l+1][j] = pp[l][j] & pp[l][j-SP];
          end
        end
      end
      assign sum = hs ^ gg[LV];
      assign co  = gen[WIDTH-1] | (prp[WIDTH-1] & gg[LV][WIDTH-1]);
    end else begin : g_sparse
      logic [SLV:0][NG-1:0] sg, sp;
      logic [NG-1:0] sgen, sprp, nco;
      for (genvar m = 0; m < NG; m++) begin : g_grp
        localparam int B = 4*m;
        assign sgen[m] = gen[B+3] | (prp[B+3] & (gen[B+2] | (prp[B+2] &
                         (gen[B+1] | (prp[B+1] & gen[B])))));
        assign sprp[m] = &prp[B+3:B];
      end
      assign sg[0][0] = ci;
      assign sp[0][0] = 1'b0;
      for (genvar m = 1; m < NG; m++) begin : g_sin
        assign sg[0][m] = sgen[m-1];
        assign sp[0][m] = sprp[m-1];
      end
      for (genvar l = 0; l < SLV; l++) begin : g_slvl
        localparam int SP = 1 << l;
        for (genvar m = 0; m < NG; m++) begin : g_snode
          if (m < SP) begin : g_pass
            assign sg[l+1][m] = sg[l][m];
            assign sp[l+1][m] = sp[l][m];
          end else if (m < 2*SP) begin : g_gray
            assign sg[l+1][m] = sg[l][m] | (sp[l][m] & sg[l][m-SP]);
            assign sp[l+1][m] = 1'b0;
          end else begin : g_black
            assign sg[l+1][m] = sg[l][m] | (sp[l][m] & sg[l][m-SP]);
            assign sp[l+1][m] = sp[l][m] & sp[l][m-SP];
          end
        end
      end
      for (genvar m = 0; m < NG; m++) begin : g_rip
        logic [4:0] rc;
        assign rc[0] = sg[SLV][m];
        for (genvar k = 0; k < 4; k++) begin : g_bit
          assign rc[k+1]     = gen[4*m+k] | (prp[4*m+k] & rc[k]);
          assign sum[4*m+k]  = hs[4*m+k] ^ rc[k];
        end
        assign nco[m] = rc[4];
      end
      assign co = nco[NG-1];
    end
  endgenerate

  always_comb begin
    p_ref_sum_r1: assert ({co, sum} == ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, ci}))
      else $error("sum mismatch");
    if (opa == '0 && opb == '0)
      p_cin_only_r3: assert (sum == {{(WIDTH-1){1'b0}}, ci} && !co)
        else $error("zero operands");
    if ((opa ^ opb) == '1)
      p_full_prop_r4: assert (co == ci && sum == {WIDTH{~ci}})
        else $error("propagate chain");
    if (opa[WIDTH-1] && opb[WIDTH-1])
      p_msb_gen_r5: assert (co)
        else $error("msb generate");
    if (opa == '1 && opb == '1)
      p_all_ones_r6: assert (co && sum == {{(WIDTH-1){1'b1}}, ci})
        else $error("all ones");
  end
endmodule

// File: tb/ks_adder_tb.sv
module ks_adder_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] a16, b16, sf16, ss16;
  logic        c16, cof16, cos16;
  logic [7:0]  a8, b8, sf8, ss8;
  logic        c8, cof8, cos8;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  ks_adder #(.WIDTH(16), .SPARSE(1'b0)) u_dut    (.opa(a16), .opb(b16), .ci(c16), .sum(sf16), .co(cof16));
  ks_adder #(.WIDTH(16), .SPARSE(1'b1)) u_dut_sp (.opa(a16), .opb(b16), .ci(c16), .sum(ss16), .co(cos16));
  ks_adder #(.WIDTH(8),  .SPARSE(1'b0)) u_dut8   (.opa(a8),  .opb(b8),  .ci(c8),  .sum(sf8),  .co(cof8));
  ks_adder #(.WIDTH(8),  .SPARSE(1'b1)) u_dut8sp (.opa(a8),  .opb(b8),  .ci(c8),  .sum(ss8),  .co(cos8));

  // {opa, opb, ci, expected {co,sum}}
  localparam logic [49:0] VEC [0:10] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h00000},
    {16'hFFFF, 16'h0001, 1'b0, 17'h10000},
    {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
    {16'h1234, 16'h4321, 1'b0, 17'h05555},
    {16'h8000, 16'h8000, 1'b1, 17'h10001},
    {16'hAAAA, 16'h5555, 1'b1, 17'h10000},
    {16'h7FFF, 16'h0001, 1'b0, 17'h08000},
    {16'hF0F0, 16'h0F0F, 1'b0, 17'h0FFFF},
    {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
    {16'h00FF, 16'h0001, 1'b1, 17'h00101},
    {16'hABCD, 16'h1111, 1'b0, 17'h0BCDE}
  };

  task automatic chk(input string req, input logic [16:0] got, input logic [16:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run16(input logic [15:0] x, input logic [15:0] y, input logic c,
                       input logic [16:0] exp, input string rf, input string rs);
    a16 = x; b16 = y; c16 = c;
    #2;
    chk(rf, {cof16, sf16}, exp);
    chk(rs, {cos16, ss16}, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0; a8 = '0; b8 = '0; c8 = 1'b0;
    #3;
    chk("R3 idle full", {cof16, sf16}, 17'h0);
    chk("R3 idle sparse", {cos16, ss16}, 17'h0);

    for (int i = 0; i < 11; i++)
      run16(VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16:0], "R1 table", "R2 table");

    run16(16'h0000, 16'h0000, 1'b1, 17'h00001, "R3 cin full", "R3 cin sparse");
    run16(16'hC3A5, 16'h3C5A, 1'b0, 17'h0FFFF, "R4 prop ci0 full", "R4 prop ci0 sparse");
    run16(16'hC3A5, 16'h3C5A, 1'b1, 17'h10000, "R4 prop ci1 full", "R4 prop ci1 sparse");
    run16(16'h8000, 16'h8000, 1'b0, 17'h10000, "R5 msb full", "R5 msb sparse");
    run16(16'hFFFE, 16'h8001, 1'b0, 17'h17FFF, "R5 msb mix full", "R5 msb mix sparse");
    run16(16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE, "R6 ones ci0 full", "R6 ones ci0 sparse");
    run16(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, "R6 ones ci1 full", "R6 ones ci1 sparse");
    run16(16'h7FFF, 16'h8000, 1'b1, 17'h10000, "R4 split full", "R4 split sparse");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] x, y;
      logic c;
      x = 16'($urandom); y = 16'($urandom); c = 1'($urandom);
      run16(x, y, c, {1'b0, x} + {1'b0, y} + {16'h0, c}, "R1 random", "R2 random");
    end

    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++) begin
          logic [8:0] e;
          a8 = 8'(x); b8 = 8'(y); c8 = 1'(c);
          e = 9'(x) + 9'(y) + 9'(c);
          #1;
          chk("R7 full 8-bit", {8'h0, cof8, sf8}, {8'h0, e});
          chk("R7 sparse 8-bit", {8'h0, cos8, ss8}, {8'h0, e});
        end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule